// File: doc/BRIEF.md
# Address Range Permission Checker

This block sits beside a bus request path and judges every request against a small table of address windows. Each window holds a base address, an exclusive limit address, an enable, separate permission bits for data reads, data writes and instruction fetches, two role masks (one consulted for reads and fetches, one for writes), a log-enable bit and a lock bit. Each request carries an address, an access kind and a 4-bit role number. One cycle after it arrives, the block reports a grant or a deny, whether any window matched, the index of the chosen window, and a log flag for denials that the matching window wants recorded.

Windows are configured through a register write port. The port selects a window index and a field, and one extra field selector reaches a global bypass bit. When the bypass bit is set, every request is granted. Once a window's lock bit is written, later writes to any field of that window are ignored until reset.

A two-state controller tracks the decision output. **IDLE** means that no decision is presented. **RESULT** means that a registered decision is on the outputs. The transition *accept* (IDLE to RESULT) happens on a valid request. The transition *stream* (RESULT to RESULT) happens on another valid request. The transition *drain* (RESULT or IDLE to IDLE) happens when no request is valid.

Top module: `addr_range_guard`

## Requirements
- R1: A window matches an address only when its enable bit (attribute bit 0) is set and base <= address < limit. An address equal to the limit does not match.
- R2: When several enabled windows match, the lowest index is reported and used for the decision.
- R3: Access kind encoding is 0 = data read, 1 = data write, 2 = instruction fetch, 3 = reserved. The permission bits are attribute bit 1 (read), bit 2 (write) and bit 3 (fetch). A matched access is denied when the bit for its kind is clear. Kind 3 is always denied unless bypass is set.
- R4: A matched access is also denied unless bit `role` of the role mask for its kind is set. The role field holds the read mask in bits 15:0 and the write mask in bits 31:16. Reads and fetches use the read mask. Writes use the write mask.
- R5: When no enabled window matches (all-index miss), the request is denied and reported with hit = 0 and index = 0.
- R6: While the global bypass bit (field select 4, data bit 0) is set, every request is granted and the log flag is 0. Hit and index are still reported from the window table.
- R7: Writing attribute bit 5 locks a window. After that, writes to its base (field select 0), limit (1), attributes (2) and roles (3) have no effect until reset.
- R8: The log flag is 1 exactly when a request is denied by a matched window whose attribute bit 4 is set.
- R9: The decision appears in the cycle after the request (`dec_valid` follows `req_valid` by one clock). In a cycle with no decision, all decision outputs are 0.
- R10: Reset clears every window and the bypass bit and drives all outputs to 0, so that after reset every request misses.
- R11: A request presented in the same cycle as a configuration write is judged against the configuration as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 fetch) |
| req_addr | input | 32 | Request address |
| req_role | input | 4 | Requester role number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window index to write |
| cfg_sel | input | 3 | Field select: 0 base, 1 limit, 2 attributes, 3 roles, 4 global bypass |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Decision valid |
| dec_grant | output | 1 | Request granted |
| dec_hit | output | 1 | Some enabled window matched |
| dec_idx | output | 3 | Index of the chosen window |
| dec_log | output | 1 | Denial to be logged |

## Verification
The hardest situations to reach from the ports are a request that coincides with a configuration write to the same window, and write attempts to a window after it has locked. In both, a wrong result looks exactly like a legal configuration. The stimulus therefore first builds overlapping windows with known boundaries. It then deliberately disables a window in the very cycle it is probed, locks a window, and tries to move that window's base and clear its attributes. Each attempt is followed by probes that would succeed only if the write had taken effect. A long pseudo-random phase then mixes writes, locks, bypass toggles and requests near window edges. A final reset shows that locks clear.

// File: rtl/arg_pkg.sv
`timescale 1ns/1ps
package arg_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        SEL_BASE   = 3'd0,
        SEL_LIMIT  = 3'd1,
        SEL_ATTR   = 3'd2,
        SEL_ROLE   = 3'd3,
        SEL_GLOBAL = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic lock;
        logic log_en;
        logic x_ok;
        logic w_ok;
        logic r_ok;
        logic en;
    } win_attr_t;

    localparam int ATTR_W = $bits(win_attr_t);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } dec_state_e;

endpackage

// File: rtl/arg_range_slot.sv
`timescale 1ns/1ps
module arg_range_slot
    import arg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ROLE_W = 4,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cfg_sel_e          wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] q_addr,
    input  acc_kind_e         q_kind,
    input  logic [ROLE_W-1:0] q_role,
    output logic              hit,
    output logic              allow,
    output logic              log_en,
    output logic              locked
);
    localparam int ROLE_N = 1 << ROLE_W;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    win_attr_t         attr_q;
    logic [ROLE_N-1:0] rmask_q;
    logic [ROLE_N-1:0] wmask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            attr_q  <= '0;
            rmask_q <= '0;
            wmask_q <= '0;
        end else if (wr_en && !attr_q.lock) begin
            case (wr_sel)
                SEL_BASE:  base_q  <= wr_data[ADDR_W-1:0];
                SEL_LIMIT: limit_q <= wr_data[ADDR_W-1:0];
                SEL_ATTR:  attr_q  <= win_attr_t'(wr_data[ATTR_W-1:0]);
                SEL_ROLE: begin
                    rmask_q <= wr_data[ROLE_N-1:0];
                    wmask_q <= wr_data[2*ROLE_N-1:ROLE_N];
                end
                default: ;
            endcase
        end
    end

    logic kind_ok;
    logic role_ok;

    always_comb begin
        unique case (q_kind)
            ACC_READ: begin
                kind_ok = attr_q.r_ok;
                role_ok = rmask_q[q_role];
            end
            ACC_WRITE: begin
                kind_ok = attr_q.w_ok;
                role_ok = wmask_q[q_role];
            end
            ACC_EXEC: begin
                kind_ok = attr_q.x_ok;
                role_ok = rmask_q[q_role];
            end
            default: begin
                kind_ok = 1'b0;
                role_ok = 1'b0;
            end
        endcase
    end

    assign hit    = attr_q.en && (q_addr >= base_q) && (q_addr < limit_q);
    assign allow  = kind_ok && role_ok;
    assign log_en = attr_q.log_en;
    assign locked = attr_q.lock;

endmodule

// File: rtl/arg_prio_pick.sv
`timescale 1ns/1ps
module arg_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end

    assign any = |hits;

endmodule

// File: rtl/addr_range_guard.sv
`timescale 1ns/1ps
module addr_range_guard
    import arg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_RANGES = 8,
    parameter int ROLE_W     = 4,
    parameter int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
    parameter int CFG_W      = (ADDR_W > 2 * (1 << ROLE_W)) ? ADDR_W : 2 * (1 << ROLE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ROLE_W-1:0] req_role,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              dec_valid,
    output logic              dec_grant,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_idx,
    output logic              dec_log
);
    cfg_sel_e  sel;
    acc_kind_e kind;

    assign sel  = cfg_sel_e'(cfg_sel);
    assign kind = acc_kind_e'(req_kind);

    logic [NUM_RANGES-1:0] hit_vec;
    logic [NUM_RANGES-1:0] allow_vec;
    logic [NUM_RANGES-1:0] log_vec;
    logic [NUM_RANGES-1:0] lock_vec;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_slot
        logic slot_we;
        assign slot_we = cfg_we && (cfg_idx == IDX_W'(g)) && (sel != SEL_GLOBAL);

        arg_range_slot #(
            .ADDR_W (ADDR_W),
            .ROLE_W (ROLE_W),
            .CFG_W  (CFG_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (slot_we),
            .wr_sel  (sel),
            .wr_data (cfg_wdata),
            .q_addr  (req_addr),
            .q_kind  (kind),
            .q_role  (req_role),
            .hit     (hit_vec[g]),
            .allow   (allow_vec[g]),
            .log_en  (log_vec[g]),
            .locked  (lock_vec[g])
        );
    end

    logic bypass_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bypass_q <= 1'b0;
        end else if (cfg_we && sel == SEL_GLOBAL) begin
            bypass_q <= cfg_wdata[0];
        end
    end

    logic             any_hit;
    logic [IDX_W-1:0] pick_idx;

    arg_prio_pick #(
        .N     (NUM_RANGES),
        .IDX_W (IDX_W)
    ) u_pick (
        .hits (hit_vec),
        .any  (any_hit),
        .idx  (pick_idx)
    );

    logic grant_d;
    logic log_d;

    always_comb begin
        grant_d = bypass_q || (any_hit && allow_vec[pick_idx]);
        log_d   = !bypass_q && any_hit && !allow_vec[pick_idx] && log_vec[pick_idx];
    end

    dec_state_e state_q;
    dec_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_grant <= 1'b0;
            dec_hit   <= 1'b0;
            dec_idx   <= '0;
            dec_log   <= 1'b0;
        end else if (state_d == ST_RESULT) begin
            dec_grant <= grant_d;
            dec_hit   <= any_hit;
            dec_idx   <= pick_idx;
            dec_log   <= log_d;
        end else begin
            dec_grant <= 1'b0;
            dec_hit   <= 1'b0;
            dec_idx   <= '0;
            dec_log   <= 1'b0;
        end
    end

    assign dec_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/arg_guard_checker.sv
`timescale 1ns/1ps
module arg_guard_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         bypass,
    input logic [N-1:0] lock_vec,
    input logic         dec_valid,
    input logic         dec_grant,
    input logic         dec_hit,
    input logic         dec_log
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);

    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_grant && !dec_hit && !dec_log));

    assert_bypass_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bypass) |=> (dec_grant && !dec_log));

    assert_miss_denies_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bypass) |=> (dec_grant -> dec_hit));

    assert_log_on_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_log |-> (dec_valid && dec_hit && !dec_grant));

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vec & $past(lock_vec)) == $past(lock_vec));

endmodule

bind addr_range_guard arg_guard_checker #(.N(NUM_RANGES)) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bypass    (bypass_q),
    .lock_vec  (lock_vec),
    .dec_valid (dec_valid),
    .dec_grant (dec_grant),
    .dec_hit   (dec_hit),
    .dec_log   (dec_log)
);

// File: tb/test_addr_range_guard.sv
`timescale 1ns/1ps
module test_addr_range_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_role = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dec_valid, dec_grant, dec_hit, dec_log;
    logic [2:0]  dec_idx;

    always #2.5 clk = ~clk;

    addr_range_guard i_addr_range_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_role(req_role), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dec_valid(dec_valid),
        .dec_grant(dec_grant), .dec_hit(dec_hit), .dec_idx(dec_idx), .dec_log(dec_log)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_base [8];
    logic [31:0] m_lim  [8];
    logic [5:0]  m_attr [8];
    logic [15:0] m_rm   [8];
    logic [15:0] m_wm   [8];
    logic        m_byp;

    bit          have_exp = 0;
    logic [4:0]  exp_vec;
    logic [2:0]  exp_idx;
    string       exp_tag;

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_attr[i] = '0; m_rm[i] = '0; m_wm[i] = '0;
        end
        m_byp = 1'b0;
    endtask

    task automatic check(string tag, logic [4:0] exp_v, logic [2:0] exp_i);
        logic [4:0] act;
        act = {dec_valid, dec_grant, dec_hit, dec_log, 1'b0};
        checks++;
        if (act !== exp_v || dec_idx !== exp_i) begin
            fails++;
            $display("FAIL %s: actual v/g/h/l=%b idx=%0d expected v/g/h/l=%b idx=%0d",
                     tag, act[4:1], dec_idx, exp_v[4:1], exp_i);
        end
    endtask

    task automatic step(bit v, logic [1:0] k, logic [31:0] a, logic [3:0] r,
                        bit we, logic [2:0] ix, logic [2:0] s, logic [31:0] d, string tag);
        int  m;
        bit  g, lg, ok;
        @(negedge clk);
        if (have_exp) check(exp_tag, exp_vec, exp_idx);
        req_valid = v; req_kind = k; req_addr = a; req_role = r;
        cfg_we = we; cfg_idx = ix; cfg_sel = s; cfg_wdata = d;
        m = -1;
        for (int i = 7; i >= 0; i--)
            if (m_attr[i][0] && a >= m_base[i] && a < m_lim[i]) m = i;
        ok = 0;
        if (m >= 0) begin
            case (k)
                2'd0: ok = m_attr[m][1] && m_rm[m][r];
                2'd1: ok = m_attr[m][2] && m_wm[m][r];
                2'd2: ok = m_attr[m][3] && m_rm[m][r];
                default: ok = 0;
            endcase
        end
        g  = m_byp || ok;
        lg = !m_byp && (m >= 0) && !ok && m_attr[m][4];
        if (v) begin
            exp_vec = {1'b1, g, (m >= 0), lg, 1'b0};
            exp_idx = (m >= 0) ? 3'(m) : 3'd0;
        end else begin
            exp_vec = '0;
            exp_idx = '0;
        end
        exp_tag = tag;
        have_exp = 1;
        if (we) begin
            if (s == 3'd4) m_byp = d[0];
            else if (!m_attr[ix][5]) begin
                case (s)
                    3'd0: m_base[ix] = d;
                    3'd1: m_lim[ix]  = d;
                    3'd2: m_attr[ix] = d[5:0];
                    3'd3: begin m_rm[ix] = d[15:0]; m_wm[ix] = d[31:16]; end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic wr(logic [2:0] ix, logic [2:0] s, logic [31:0] d, string tag);
        step(0, 0, 0, 0, 1, ix, s, d, tag);
    endtask

    task automatic rq(logic [1:0] k, logic [31:0] a, logic [3:0] r, string tag);
        step(1, k, a, r, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        if (have_exp) check(exp_tag, exp_vec, exp_idx);
        have_exp = 0;
        rst_n = 0;
        req_valid = 0; cfg_we = 0;
        model_clear();
        @(negedge clk);
        check("R10 reset outputs", 5'b0, 3'd0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        rq(0, 32'h10, 0, "R10 miss after reset");
        rq(2, 32'h0, 0, "R5 miss deny");
        wr(0, 0, 32'h100, "R9 idle");
        wr(0, 1, 32'h200, "R9 idle");
        wr(0, 3, 32'h0001_FFFF, "R9 idle");
        wr(0, 2, 32'h07, "R9 idle");
        wr(1, 0, 32'h180, "R9 idle");
        wr(1, 1, 32'h300, "R9 idle");
        wr(1, 3, 32'hFFFF_FFFF, "R9 idle");
        wr(1, 2, 32'h1F, "R9 idle");
        rq(0, 32'h100, 0, "R1 base inclusive");
        rq(0, 32'h1FF, 0, "R1 last address");
        rq(0, 32'h200, 0, "R1 limit exclusive");
        rq(0, 32'h180, 0, "R2 lowest index wins");
        rq(1, 32'h150, 0, "R4 write role allowed");
        rq(1, 32'h150, 3, "R4 write role denied");
        rq(2, 32'h150, 0, "R3 fetch bit clear");
        rq(2, 32'h250, 5, "R3 fetch allowed");
        rq(3, 32'h250, 0, "R8 reserved kind logged");
        wr(1, 3, 32'hFFFF_0004, "R9 idle");
        rq(0, 32'h250, 1, "R4 R8 read role denied");
        rq(2, 32'h250, 2, "R4 fetch via read mask");
        step(1, 0, 32'h250, 2, 1, 1, 2, 32'h0, "R11 old config used");
        rq(0, 32'h250, 2, "R1 disabled never matches");
        wr(0, 4, 32'h1, "R9 idle");
        rq(0, 32'h250, 9, "R6 bypass miss grants");
        rq(1, 32'h150, 3, "R6 bypass overrides role");
        wr(0, 4, 32'h0, "R9 idle");
        wr(0, 2, 32'h23, "R9 idle");
        wr(0, 0, 32'h0, "R9 idle");
        rq(0, 32'h50, 0, "R7 locked base unchanged");
        wr(0, 2, 32'h0, "R9 idle");
        rq(0, 32'h150, 0, "R7 locked attr unchanged");
        rq(1, 32'h150, 0, "R3 write bit clear");
        step(0, 0, 32'h150, 0, 0, 0, 0, 0, "R9 no request zeros");
        for (int n = 0; n < 1500; n++) begin
            bit v, we;
            logic [2:0] s;
            logic [31:0] d;
            v  = ($urandom_range(0, 3) != 0);
            we = ($urandom_range(0, 2) == 0);
            s  = 3'($urandom_range(0, 4));
            if (s == 3'd4) s = ($urandom_range(0, 3) == 0) ? 3'd4 : 3'd2;
            case (s)
                3'd2: d = {26'd0, ($urandom_range(0, 9) == 0), 5'($urandom)};
                3'd4: d = {31'd0, ($urandom_range(0, 2) == 0)};
                3'd3: d = $urandom;
                default: d = 32'($urandom_range(0, 32'h3FF));
            endcase
            step(v, 2'($urandom), 32'($urandom_range(0, 32'h3FF)), 4'($urandom),
                 we, 3'($urandom), s, d, "R2 mixed traffic");
        end
        do_reset();
        wr(0, 0, 32'h40, "R9 idle");
        wr(0, 1, 32'h80, "R9 idle");
        wr(0, 3, 32'h0000_0001, "R9 idle");
        wr(0, 2, 32'h03, "R9 idle");
        rq(0, 32'h40, 0, "R7 lock cleared by reset");
        rq(0, 32'h7F, 1, "R4 role bit clear");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9 no request zeros");
        @(negedge clk);
        if (have_exp) check(exp_tag, exp_vec, exp_idx);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule